// File: doc/BRIEF.md
# Dual-Trigger Acquisition Sequencer

This block turns trigger requests into frame acquisition commands for a detector readout chain. Three sources can produce triggers: an external timing receiver with separate run and DAQ channels, an internal periodic generator, and a software strobe pair. A 2-bit select input picks one source. Triggers from the other sources are discarded.

A run trigger arms the sequencer for a programmable window. A DAQ trigger inside that window launches a frame whose data is forwarded downstream. If the window closes with no DAQ trigger, the frame is still launched, but its data is marked for discard. Run-only frames keep the sensor cycling at a steady thermal load between real acquisitions.

Each launch emits a one-cycle start pulse. It also emits a forward flag and a frame number for the packet header. After a launch the sequencer stays busy for a programmable number of cycles. Run triggers that arrive while it is armed or busy are dropped and counted. DAQ triggers with no pending run trigger are counted as errors.

Top module: `trig_seq`

## Requirements
- R1: After reset, `acq_start_o`, `fwd_en_o` and `busy_o` are 0, and `acq_id_o`, `drop_cnt_o` and `daq_err_cnt_o` are 0.
- R2: `src_sel_i` selects the source: 0 = timing receiver (`tmr_*`), 1 = internal generator, 2 = software (`sw_*`), 3 = none. Triggers on unselected inputs change no output and no counter.
- R3: The sequencer arms on a run trigger while idle. The window setting is W, with W ≥ 1. If a DAQ trigger arrives d cycles after the run trigger, with 1 ≤ d ≤ W, `acq_start_o` pulses in cycle d+1 with `fwd_en_o` = 1.
- R4: If no DAQ trigger arrives within cycles 1..W after the run trigger, `acq_start_o` pulses in cycle W+1 with `fwd_en_o` = 0.
- R5: `acq_start_o` is high for exactly one cycle. During the pulse, `acq_id_o` equals the number of earlier launches. `acq_id_o` and `fwd_en_o` hold their values between pulses.
- R6: `busy_o` is high from the cycle after an accepted run trigger until the launch, and then for `acq_len_i` = L cycles counted from the start pulse (L ≥ 1). It is low in cycle L after the pulse.
- R7: A run trigger that arrives while `busy_o` is high, or in the last busy cycle, is dropped. It increments `drop_cnt_o` by one.
- R8: A DAQ trigger that arrives while not armed increments `daq_err_cnt_o` by one. This covers an idle sequencer, an acquisition already underway, and a window that has already closed. Such a trigger launches nothing.
- R9: With source 1 selected and period P > 0, the generator issues a run trigger every P cycles. The first start pulse appears P+2 cycles after selection when `auto_daq_en_i` = 1, because a DAQ trigger follows one cycle after each run trigger. With `auto_daq_en_i` = 0, the first pulse appears P+W+1 cycles after selection. P = 0 issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 2 | Trigger source select |
| tmr_run_i | input | 1 | Timing receiver run trigger pulse |
| tmr_daq_i | input | 1 | Timing receiver DAQ trigger pulse |
| sw_run_i | input | 1 | Software run trigger strobe |
| sw_daq_i | input | 1 | Software DAQ trigger strobe |
| auto_period_i | input | CNT_W | Internal generator period in cycles, 0 = off |
| auto_daq_en_i | input | 1 | Generator also issues a DAQ trigger one cycle after each run trigger |
| daq_win_i | input | WIN_W | DAQ acceptance window W in cycles |
| acq_len_i | input | LEN_W | Acquisition busy length L in cycles |
| acq_start_o | output | 1 | One-cycle frame launch pulse |
| fwd_en_o | output | 1 | Frame data is forwarded when 1 and discarded when 0 |
| busy_o | output | 1 | Armed or acquiring |
| acq_id_o | output | CNT_W | Frame number for the header |
| drop_cnt_o | output | CNT_W | Count of dropped run triggers |
| daq_err_cnt_o | output | CNT_W | Count of DAQ triggers with no pending run trigger |

## Verification
The hardest cases to reach are the window and busy edges. These are a DAQ trigger arriving exactly at W or one cycle after W, and a run trigger arriving in the last busy cycle. Both depend on the timing between two strobes. The stimulus draws the DAQ delay at random from 1 to W+2 for random windows, so it lands on both sides of the boundary. It also places an extra run trigger in the first armed cycle or in the final busy cycle. The generator timing is checked by measuring the spacing between start pulses.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  typedef enum logic [1:0] {
    SRC_TMR  = 2'd0,
    SRC_AUTO = 2'd1,
    SRC_SW   = 2'd2,
    SRC_OFF  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_ACQ  = 2'd2
  } st_e;

  typedef struct packed {
    logic run;
    logic daq;
  } trig_t;

  localparam int NUM_SRC = 3;
endpackage

// File: rtl/trig_auto_gen.sv
module trig_auto_gen
  import trig_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             daq_en_i,
  output trig_t            trig_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, daq_q;
  logic             live;

  assign live = en_i && (period_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      daq_q <= 1'b0;
    end else begin
      daq_q <= run_q && daq_en_i && live;
      if (!live) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else if (cnt_q == period_i - 1'b1) begin
        cnt_q <= '0;
        run_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        run_q <= 1'b0;
      end
    end
  end

  assign trig_o = '{run: run_q, daq: daq_q};
endmodule

// File: rtl/trig_src_mux.sv
module trig_src_mux
  import trig_seq_pkg::*;
#(
  parameter int N     = NUM_SRC,
  parameter int SEL_W = 2
) (
  input  trig_t            src_i [N],
  input  logic [SEL_W-1:0] sel_i,
  output trig_t            trig_o
);
  trig_t gated [N];

  for (genvar g = 0; g < N; g++) begin : g_gate
    assign gated[g] = (sel_i == SEL_W'(g)) ? src_i[g] : '0;
  end

  always_comb begin
    trig_o = '0;
    for (int i = 0; i < N; i++) trig_o = trig_o | gated[i];
  end
endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
  import trig_seq_pkg::*;
#(
  parameter int WIN_W = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  trig_t            trig_i,
  input  logic [WIN_W-1:0] daq_win_i,
  input  logic [LEN_W-1:0] acq_len_i,
  output logic             start_d_o,
  output logic             drop_d_o,
  output logic             err_d_o,
  output logic             start_o,
  output logic             fwd_o,
  output logic             busy_o
);
  st_e              st_q, st_n;
  logic [WIN_W-1:0] win_q, win_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic             fwd_n;

  always_comb begin
    st_n      = st_q;
    win_n     = win_q;
    len_n     = len_q;
    start_d_o = 1'b0;
    fwd_n     = 1'b0;
    drop_d_o  = 1'b0;
    err_d_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        err_d_o = trig_i.daq;
        if (trig_i.run) begin
          st_n  = ST_ARM;
          win_n = WIN_W'(1);
        end
      end
      ST_ARM: begin
        drop_d_o = trig_i.run;
        if (trig_i.daq || win_q >= daq_win_i) begin
          start_d_o = 1'b1;
          fwd_n     = trig_i.daq;
          st_n      = ST_ACQ;
          len_n     = LEN_W'(1);
        end else begin
          win_n = win_q + 1'b1;
        end
      end
      default: begin
        drop_d_o = trig_i.run;
        err_d_o  = trig_i.daq;
        if (len_q >= acq_len_i) st_n = ST_IDLE;
        else                    len_n = len_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      win_q   <= '0;
      len_q   <= '0;
      start_o <= 1'b0;
      fwd_o   <= 1'b0;
    end else begin
      st_q    <= st_n;
      win_q   <= win_n;
      len_q   <= len_n;
      start_o <= start_d_o;
      if (start_d_o) fwd_o <= fwd_n;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/trig_evt_cnt.sv
module trig_evt_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int WIN_W = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       src_sel_i,
  input  logic             tmr_run_i,
  input  logic             tmr_daq_i,
  input  logic             sw_run_i,
  input  logic             sw_daq_i,
  input  logic [CNT_W-1:0] auto_period_i,
  input  logic             auto_daq_en_i,
  input  logic [WIN_W-1:0] daq_win_i,
  input  logic [LEN_W-1:0] acq_len_i,
  output logic             acq_start_o,
  output logic             fwd_en_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] acq_id_o,
  output logic [CNT_W-1:0] drop_cnt_o,
  output logic [CNT_W-1:0] daq_err_cnt_o
);
  trig_t            src [NUM_SRC];
  trig_t            sel_trig;
  logic             start_d, drop_d, err_d;
  logic [CNT_W-1:0] acq_cnt;

  assign src[SRC_TMR] = '{run: tmr_run_i, daq: tmr_daq_i};
  assign src[SRC_SW]  = '{run: sw_run_i,  daq: sw_daq_i};

  trig_auto_gen #(.CNT_W(CNT_W)) i_auto (
    .clk_i, .rst_ni,
    .en_i     (src_sel_i == SRC_AUTO),
    .period_i (auto_period_i),
    .daq_en_i (auto_daq_en_i),
    .trig_o   (src[SRC_AUTO])
  );

  trig_src_mux #(.N(NUM_SRC), .SEL_W(2)) i_mux (
    .src_i  (src),
    .sel_i  (src_sel_i),
    .trig_o (sel_trig)
  );

  trig_seq_fsm #(.WIN_W(WIN_W), .LEN_W(LEN_W)) i_fsm (
    .clk_i, .rst_ni,
    .trig_i    (sel_trig),
    .daq_win_i,
    .acq_len_i,
    .start_d_o (start_d),
    .drop_d_o  (drop_d),
    .err_d_o   (err_d),
    .start_o   (acq_start_o),
    .fwd_o     (fwd_en_o),
    .busy_o
  );

  trig_evt_cnt #(.W(CNT_W)) i_acq_cnt  (.clk_i, .rst_ni, .inc_i(start_d), .cnt_o(acq_cnt));
  trig_evt_cnt #(.W(CNT_W)) i_drop_cnt (.clk_i, .rst_ni, .inc_i(drop_d),  .cnt_o(drop_cnt_o));
  trig_evt_cnt #(.W(CNT_W)) i_err_cnt  (.clk_i, .rst_ni, .inc_i(err_d),   .cnt_o(daq_err_cnt_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acq_id_o <= '0;
    else if (start_d) acq_id_o <= acq_cnt;
  end
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       src_sel_i,
  input logic             acq_start_o,
  input logic             fwd_en_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] acq_id_o,
  input logic [CNT_W-1:0] drop_cnt_o,
  input logic [CNT_W-1:0] daq_err_cnt_o
);
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_start_o |=> !acq_start_o);

  a_r5_id_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acq_start_o |-> $stable(acq_id_o));

  a_r5_fwd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acq_start_o |-> $stable(fwd_en_o));

  a_r6_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_start_o |-> busy_o);

  a_r7_drop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drop_cnt_o) |-> drop_cnt_o == $past(drop_cnt_o) + 1'b1);

  a_r8_err_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(daq_err_cnt_o) |-> daq_err_cnt_o == $past(daq_err_cnt_o) + 1'b1);

  a_r2_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 2'd3 && !busy_o) |=> !busy_o);
endmodule

bind trig_seq trig_seq_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_trig_seq.sv
`timescale 1ns/1ps
module test_trig_seq;
  localparam int CW = 32;
  localparam int L  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    src_sel = 2'd2;
  logic          tmr_run = 0, tmr_daq = 0, sw_run = 0, sw_daq = 0;
  logic [CW-1:0] period = '0;
  logic          auto_daq = 0;
  logic [7:0]    win = 8'd3;
  logic [15:0]   alen = 16'(L);
  logic          start, fwd, busy;
  logic [CW-1:0] acq_id, drop_cnt, err_cnt;

  int n_chk = 0, n_fail = 0;
  int exp_acq = 0, exp_drop = 0, exp_err = 0;

  always #2 clk = ~clk;

  trig_seq i_trig_seq (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(src_sel),
    .tmr_run_i(tmr_run), .tmr_daq_i(tmr_daq), .sw_run_i(sw_run), .sw_daq_i(sw_daq),
    .auto_period_i(period), .auto_daq_en_i(auto_daq), .daq_win_i(win), .acq_len_i(alen),
    .acq_start_o(start), .fwd_en_o(fwd), .busy_o(busy), .acq_id_o(acq_id),
    .drop_cnt_o(drop_cnt), .daq_err_cnt_o(err_cnt)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drv(bit tmr, bit r, bit d);
    if (tmr) begin tmr_run = r; tmr_daq = d; end
    else     begin sw_run = r;  sw_daq = d;  end
  endtask

  function automatic int launch_cycle(int w, int d);
    return (d <= w) ? d + 1 : w + 1;
  endfunction

  task automatic txn(bit tmr, int w, int d, bit extra, bit late);
    int k;
    bit f;
    f = (d <= w);
    k = launch_cycle(w, d);
    win = 8'(w);
    @(negedge clk); drv(tmr, 1, 0);
    for (int c = 1; c <= k + L; c++) begin
      @(negedge clk);
      if (c < k) begin
        chk(start == 0, "R3", "no early start", start, 0);
        chk(busy == 1, "R6", "busy while armed", busy, 1);
      end
      if (c == k) begin
        chk(start == 1, f ? "R3" : "R4", "start pulse", start, 1);
        chk(fwd == f, f ? "R3" : "R4", "fwd flag", fwd, f);
        chk(acq_id == CW'(exp_acq), "R5", "frame id", acq_id, exp_acq);
      end
      if (c == k + 1) chk(start == 0, "R5", "pulse width", start, 0);
      if (c == k + L - 1) chk(busy == 1, "R6", "busy last cycle", busy, 1);
      if (c == k + L) chk(busy == 0, "R6", "busy end", busy, 0);
      drv(tmr, (extra && c == 1) || (late && c == k + L - 1), c == d);
    end
    drv(tmr, 0, 0);
    exp_acq++;
    exp_drop += int'(extra) + int'(late);
    exp_err += int'(!f);
    chk(drop_cnt == CW'(exp_drop), "R7", "drop count", drop_cnt, exp_drop);
    chk(err_cnt == CW'(exp_err), "R8", "daq error count", err_cnt, exp_err);
    chk(acq_id == CW'(exp_acq - 1), "R5", "id held", acq_id, exp_acq - 1);
  endtask

  task automatic auto_run(bit daq_en, int p, int w);
    int t0, t_prev, seen, expf;
    win = 8'(w); auto_daq = daq_en; period = CW'(p);
    @(negedge clk); src_sel = 2'd1;
    t0 = 0; t_prev = 0; seen = 0;
    expf = daq_en ? p + 2 : p + w + 1;
    for (int c = 1; c <= 3 * p + w + 4 && seen < 3; c++) begin
      @(negedge clk);
      if (start) begin
        if (seen == 0) chk(c == expf, "R9", "first auto start", c, expf);
        else           chk(c - t_prev == p, "R9", "auto period", c - t_prev, p);
        chk(fwd == daq_en, "R9", "auto fwd", fwd, daq_en);
        chk(acq_id == CW'(exp_acq), "R5", "auto frame id", acq_id, exp_acq);
        exp_acq++;
        t_prev = c; seen++;
      end
    end
    chk(seen == 3, "R9", "auto start count", seen, 3);
    src_sel = 2'd3;
    repeat (p + L + 4) @(negedge clk);
    chk(busy == 0, "R2", "idle after off", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(start == 0 && fwd == 0 && busy == 0, "R1", "reset outputs", {start, fwd, busy}, 0);
    chk(acq_id == 0 && drop_cnt == 0 && err_cnt == 0, "R1", "reset counters",
        acq_id | drop_cnt | err_cnt, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R8: DAQ with nothing armed
    sw_daq = 1; @(negedge clk); sw_daq = 0; exp_err++;
    @(negedge clk);
    chk(err_cnt == CW'(exp_err), "R8", "idle daq", err_cnt, exp_err);
    chk(busy == 0, "R8", "idle daq no arm", busy, 0);

    // R3/R4 window edges, software source
    txn(0, 3, 3, 0, 0);
    txn(0, 3, 4, 0, 0);
    txn(0, 1, 1, 1, 1);
    txn(0, 5, 7, 1, 0);

    // R2: timing source
    src_sel = 2'd0;
    txn(1, 2, 1, 0, 1);
    txn(1, 4, 6, 0, 0);

    // R2: unselected and none
    sw_run = 1; @(negedge clk); sw_run = 0; sw_daq = 1; @(negedge clk); sw_daq = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && acq_id == CW'(exp_acq - 1), "R2", "sw ignored under tmr", busy, 0);
    chk(err_cnt == CW'(exp_err), "R2", "sw daq ignored", err_cnt, exp_err);
    src_sel = 2'd3;
    tmr_run = 1; @(negedge clk); tmr_run = 0; tmr_daq = 1; @(negedge clk); tmr_daq = 0;
    sw_run = 1; @(negedge clk); sw_run = 0;
    repeat (4) @(negedge clk);
    chk(busy == 0 && start == 0, "R2", "none selected", busy, 0);
    chk(err_cnt == CW'(exp_err) && drop_cnt == CW'(exp_drop), "R2", "counters unchanged",
        err_cnt, exp_err);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int w, d;
      bit t;
      t = 1'($urandom % 2);
      src_sel = t ? 2'd0 : 2'd2;
      w = int'($urandom_range(1, 6));
      d = int'($urandom_range(1, w + 2));
      txn(t, w, d, 1'($urandom % 2), 1'($urandom % 2));
    end

    // R9: internal generator
    auto_run(1, 20, 3);
    auto_run(0, 24, 4);
    period = '0; auto_daq = 1;
    @(negedge clk); src_sel = 2'd1;
    repeat (60) @(negedge clk);
    chk(busy == 0 && acq_id == CW'(exp_acq - 1), "R9", "period zero silent", busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule